// File: doc/BRIEF.md
# UART Receive Holding Buffer with Overrun Handling

This block holds received characters on the receive side of a UART. A shift register upstream pulses `char_done` with a finished character. The block keeps that character until the CPU or a DMA engine takes it. It has two modes, selected by `fifo_en`. In single mode there is one holding slot and a data-ready flag. In queue mode up to `DEPTH` characters (8 by default) are kept in arrival order, and a programmable fill threshold gives an extra level-based flag.

When a character completes and no slot is free, the block records an overrun. It keeps the data it already holds, throws away the incoming character and sets a sticky flag. The flag stays set until software writes a one to its clear input. A break character is reported as a framing error. A detected idle line sets an idle flag. One interrupt line combines all flags under their enables. A DMA request is raised whenever data is waiting and DMA is enabled.

`fifo_en` is sampled continuously and is expected to change only while reset is asserted.

Top module: `uart_rx_holding`

## Requirements
- R1: After reset the block holds no data, `rx_level` is 0, and `data_ready`, `thr_reached`, `ovr_flag`, `frm_flag`, `idle_flag`, `dma_req` and `irq` are all 0.
- R2: A `char_done` pulse with `char_break` low stores `char_data` if a slot is free. `data_ready` is 1 from the next cycle, and in single mode `rx_level` never exceeds 1.
- R3: A pulse on `rd_pop` or `dma_ack` while data is held removes the oldest character. `rd_data` always shows the oldest held character, so characters leave in arrival order. A pop while empty has no effect.
- R4: In single mode, a character that completes while `data_ready` is 1 sets `ovr_flag`. The held character is kept on `rd_data` and the new one is discarded.
- R5: In queue mode up to `DEPTH` characters are held. A character that completes while `rx_level` equals `DEPTH` sets `ovr_flag`, and the held contents and `rx_level` are unchanged.
- R6: Whether the block is full is judged before any pop in the same cycle. A character completing in the same cycle as a pop on a full buffer is an overrun and is discarded. In single mode this leaves `ovr_flag` at 1 and `data_ready` at 0.
- R7: `ovr_flag` is sticky and clears only in a cycle where `clr_ovr` is 1 and no new overrun occurs. A new overrun wins over a clear in the same cycle.
- R8: A `char_done` pulse with `char_break` high sets the sticky `frm_flag` and stores nothing. `clr_frm` clears the flag, and a new break wins over a clear in the same cycle.
- R9: An `idle_seen` pulse sets the sticky `idle_flag`, which `clr_idle` clears. The idle flag drives `irq` only while `ie_idle` is 1.
- R10: `thr_reached` is 1 exactly when `fifo_en` is 1, `rx_level` is nonzero and `rx_level` is at least `thr_level`. It is always 0 in single mode.
- R11: `dma_req` equals `dma_en` AND `data_ready`.
- R12: `irq` = (`ie_data` & `data_ready`) | ((`ie_data` | `ie_err`) & `ovr_flag`) | (`ie_err` & `frm_flag`) | (`ie_idle` & `idle_flag`) | (`ie_thr` & `thr_reached`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects single-slot mode |
| thr_level | input | CNT_W (4) | Fill threshold for `thr_reached` |
| char_done | input | 1 | One-cycle pulse: a character finished in the shift register |
| char_data | input | DW (8) | Character value carried with `char_done` |
| char_break | input | 1 | Marks the completed character as a break |
| idle_seen | input | 1 | One-cycle pulse: idle line detected |
| rd_pop | input | 1 | CPU read of the data register, which removes the oldest character |
| dma_en | input | 1 | Enables the DMA request |
| dma_ack | input | 1 | DMA read, which removes the oldest character |
| clr_ovr | input | 1 | Write-one clear of the overrun flag |
| clr_frm | input | 1 | Write-one clear of the framing flag |
| clr_idle | input | 1 | Write-one clear of the idle flag |
| ie_data | input | 1 | Data-available interrupt enable (also enables overrun) |
| ie_err | input | 1 | Error interrupt enable (overrun, framing) |
| ie_idle | input | 1 | Idle interrupt enable |
| ie_thr | input | 1 | Threshold interrupt enable |
| rd_data | output | DW (8) | Oldest held character |
| data_ready | output | 1 | At least one character is held |
| rx_level | output | CNT_W (4) | Number of characters held |
| thr_reached | output | 1 | Fill level at or above the threshold |
| ovr_flag | output | 1 | Sticky overrun flag |
| frm_flag | output | 1 | Sticky framing-error (break) flag |
| idle_flag | output | 1 | Sticky idle flag |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a pop landing in the same cycle as a character that completes on a full buffer. That is the case where `ovr_flag` reads 1 while `data_ready` reads 0. The bench drives it directly in both modes: it fills the buffer, then raises `rd_pop` and `char_done` on the same falling edge. Long random phases with dense character traffic and sparse reads keep the queue at its upper limit for long stretches. During these phases the bench also mixes in clear writes that coincide with new overruns, breaks and idle pulses, checking that a new event wins over a same-cycle clear. A behavioural queue model is compared with every output on every cycle.

// File: rtl/uart_rxh_pkg.sv
package uart_rxh_pkg;

  // Number of characters the block may hold in the selected mode.
  function automatic int unsigned cap_of(input logic fifo_mode, input int unsigned depth);
    return fifo_mode ? depth : 32'd1;
  endfunction

  // Level-based threshold test: nonzero occupancy at or above the threshold.
  function automatic logic thr_hit(input int unsigned cnt, input int unsigned thr);
    return (cnt != 0) && (cnt >= thr);
  endfunction

  // Order of the sticky flags in the flag vector.
  typedef enum int unsigned {
    FLG_OVR  = 0,
    FLG_FRM  = 1,
    FLG_IDLE = 2
  } rxh_flag_e;

  localparam int unsigned NUM_FLAGS = 3;

endpackage

// File: rtl/rxh_store.sv
module rxh_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    head,
  output logic [CNT_W-1:0] count
);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= adv(wr_ptr);
      if (pop)  rd_ptr <= adv(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rd_ptr];

  // R5: storage never written past its capacity
  a_r5_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (32'(count) < DEPTH));
  // R3: a pop is only issued when data is held
  a_r3_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));

endmodule

// File: rtl/rxh_sticky.sv
module rxh_sticky #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end

    // R7: an event wins over a same-cycle clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);
    // R7: without a clear a set flag stays set
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (q[i] && !clr[i]) |=> q[i]);
  end

endmodule

// File: rtl/rxh_irq.sv
module rxh_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ready,
  input  logic ovr,
  input  logic frm,
  input  logic idle,
  input  logic thr,
  input  logic ie_data,
  input  logic ie_err,
  input  logic ie_idle,
  input  logic ie_thr,
  output logic irq
);

  logic src_data, src_ovr, src_frm, src_idle, src_thr;

  always_comb begin
    src_data = ie_data & ready;
    src_ovr  = (ie_data | ie_err) & ovr;
    src_frm  = ie_err & frm;
    src_idle = ie_idle & idle;
    src_thr  = ie_thr & thr;
    irq      = src_data | src_ovr | src_frm | src_idle | src_thr;
  end

  // R12: with every enable low the line stays quiet
  a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(ie_data || ie_err || ie_idle || ie_thr) |-> !irq);
  // R9: the idle flag alone does not interrupt without its enable
  a_r9_idle_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_data && !ie_err && !ie_thr && !ie_idle && idle) |-> !irq);

endmodule

// File: rtl/uart_rx_holding.sv
module uart_rx_holding #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [CNT_W-1:0] thr_level,
  input  logic             char_done,
  input  logic [DW-1:0]    char_data,
  input  logic             char_break,
  input  logic             idle_seen,
  input  logic             rd_pop,
  input  logic             dma_en,
  input  logic             dma_ack,
  input  logic             clr_ovr,
  input  logic             clr_frm,
  input  logic             clr_idle,
  input  logic             ie_data,
  input  logic             ie_err,
  input  logic             ie_idle,
  input  logic             ie_thr,
  output logic [DW-1:0]    rd_data,
  output logic             data_ready,
  output logic [CNT_W-1:0] rx_level,
  output logic             thr_reached,
  output logic             ovr_flag,
  output logic             frm_flag,
  output logic             idle_flag,
  output logic             dma_req,
  output logic             irq
);
  import uart_rxh_pkg::*;

  // Named internal events
  logic is_char, full_now, take, ovr_evt, brk_evt, pop;
  logic [NUM_FLAGS-1:0] flg_set, flg_clr, flg_q;

  always_comb begin
    full_now = 32'(rx_level) >= cap_of(fifo_en, DEPTH);
    is_char  = char_done & ~char_break;
    take     = is_char & ~full_now;
    ovr_evt  = is_char & full_now;
    brk_evt  = char_done & char_break;
    pop      = (rd_pop | dma_ack) & (rx_level != '0);
  end

  rxh_store #(.DEPTH(DEPTH), .DW(DW)) i_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (take),
    .pop   (pop),
    .wdata (char_data),
    .head  (rd_data),
    .count (rx_level)
  );

  always_comb begin
    flg_set = '0;
    flg_clr = '0;
    flg_set[FLG_OVR]  = ovr_evt;
    flg_set[FLG_FRM]  = brk_evt;
    flg_set[FLG_IDLE] = idle_seen;
    flg_clr[FLG_OVR]  = clr_ovr;
    flg_clr[FLG_FRM]  = clr_frm;
    flg_clr[FLG_IDLE] = clr_idle;
  end

  rxh_sticky #(.N(NUM_FLAGS)) i_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flg_set),
    .clr   (flg_clr),
    .q     (flg_q)
  );

  assign ovr_flag    = flg_q[FLG_OVR];
  assign frm_flag    = flg_q[FLG_FRM];
  assign idle_flag   = flg_q[FLG_IDLE];
  assign data_ready  = rx_level != '0;
  assign thr_reached = fifo_en & thr_hit(32'(rx_level), 32'(thr_level));
  assign dma_req     = dma_en & data_ready;

  rxh_irq i_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready   (data_ready),
    .ovr     (ovr_flag),
    .frm     (frm_flag),
    .idle    (idle_flag),
    .thr     (thr_reached),
    .ie_data (ie_data),
    .ie_err  (ie_err),
    .ie_idle (ie_idle),
    .ie_thr  (ie_thr),
    .irq     (irq)
  );

  // R4: an overrunning character raises the flag
  a_r4_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ovr_flag);
  // R5: an overrun without pop leaves the held contents alone
  a_r5_hold_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && !pop) |=> $stable(rx_level));
  // R6: overrun with a same-cycle pop drops exactly one entry
  a_r6_pop_during_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && pop) |=> (rx_level == $past(rx_level) - 1'b1));
  // R2: single mode never holds more than one character
  a_r2_single_cap: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> (rx_level <= CNT_W'(1)));
  // R8: a break never changes the held count by itself
  a_r8_break_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_evt && !pop) |=> $stable(rx_level));
  // R10: the threshold flag is silent in single mode
  a_r10_thr_mode: assert property (@(posedge clk) disable iff (!rst_n)
    thr_reached |-> fifo_en);

endmodule

// File: tb/test_uart_rx_holding.sv
module test_uart_rx_holding;
  localparam int DEPTH = 8;
  localparam int DW    = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic fifo_en = 0;
  logic [CNT_W-1:0] thr_level = '0;
  logic char_done = 0, char_break = 0, idle_seen = 0, rd_pop = 0;
  logic [DW-1:0] char_data = '0;
  logic dma_en = 0, dma_ack = 0, clr_ovr = 0, clr_frm = 0, clr_idle = 0;
  logic ie_data = 0, ie_err = 0, ie_idle = 0, ie_thr = 0;
  logic [DW-1:0] rd_data;
  logic data_ready, thr_reached, ovr_flag, frm_flag, idle_flag, dma_req, irq;
  logic [CNT_W-1:0] rx_level;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  uart_rx_holding #(.DEPTH(DEPTH), .DW(DW)) i_uart_rx_holding (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .thr_level(thr_level),
    .char_done(char_done), .char_data(char_data), .char_break(char_break),
    .idle_seen(idle_seen), .rd_pop(rd_pop), .dma_en(dma_en), .dma_ack(dma_ack),
    .clr_ovr(clr_ovr), .clr_frm(clr_frm), .clr_idle(clr_idle),
    .ie_data(ie_data), .ie_err(ie_err), .ie_idle(ie_idle), .ie_thr(ie_thr),
    .rd_data(rd_data), .data_ready(data_ready), .rx_level(rx_level),
    .thr_reached(thr_reached), .ovr_flag(ovr_flag), .frm_flag(frm_flag),
    .idle_flag(idle_flag), .dma_req(dma_req), .irq(irq)
  );

  // Behavioural reference model
  logic [DW-1:0] q[$];
  bit m_ovr, m_frm, m_idle;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_ovr = 0; m_frm = 0; m_idle = 0;
    end else begin
      int cap;
      bit full, popit, chr;
      cap   = fifo_en ? DEPTH : 1;
      full  = q.size() >= cap;
      popit = (rd_pop || dma_ack) && q.size() > 0;
      chr   = char_done && !char_break;
      if (popit) void'(q.pop_front());
      if (chr && !full) q.push_back(char_data);
      if (chr && full) m_ovr = 1; else if (clr_ovr) m_ovr = 0;
      if (char_done && char_break) m_frm = 1; else if (clr_frm) m_frm = 0;
      if (idle_seen) m_idle = 1; else if (clr_idle) m_idle = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    bit ne, thr, irqx;
    ne   = q.size() != 0;
    thr  = fifo_en && ne && (q.size() >= int'(thr_level));
    irqx = (ie_data && ne) || ((ie_data || ie_err) && m_ovr) || (ie_err && m_frm)
        || (ie_idle && m_idle) || (ie_thr && thr);
    chk(data_ready == ne, "R2 data_ready", data_ready, ne);
    chk(int'(rx_level) == q.size(), "R5 rx_level", rx_level, q.size());
    if (ne) chk(rd_data == q[0], "R3 rd_data", rd_data, q[0]);
    chk(ovr_flag == m_ovr, "R7 ovr_flag", ovr_flag, m_ovr);
    chk(frm_flag == m_frm, "R8 frm_flag", frm_flag, m_frm);
    chk(idle_flag == m_idle, "R9 idle_flag", idle_flag, m_idle);
    chk(thr_reached == thr, "R10 thr_reached", thr_reached, thr);
    chk(dma_req == (dma_en && ne), "R11 dma_req", dma_req, dma_en && ne);
    chk(irq == irqx, "R12 irq", irq, irqx);
  endtask

  task automatic tick();
    @(negedge clk);
    if (rst_n) cmp_all();
  endtask

  task automatic quiet();
    char_done = 0; char_break = 0; idle_seen = 0; rd_pop = 0; dma_ack = 0;
    clr_ovr = 0; clr_frm = 0; clr_idle = 0;
  endtask

  task automatic put(input logic [DW-1:0] d);
    char_done = 1; char_data = d; tick(); quiet();
  endtask

  task automatic do_reset(input bit mode);
    quiet();
    rst_n = 0; fifo_en = mode;
    repeat (2) @(negedge clk);
    rst_n = 1;
    tick();
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      char_done  = ($urandom_range(0, 99) < 55);
      char_break = ($urandom_range(0, 99) < 6);
      char_data  = DW'($urandom);
      idle_seen  = ($urandom_range(0, 99) < 4);
      rd_pop     = ($urandom_range(0, 99) < 30);
      dma_ack    = ($urandom_range(0, 99) < 8);
      clr_ovr    = ($urandom_range(0, 99) < 7);
      clr_frm    = ($urandom_range(0, 99) < 7);
      clr_idle   = ($urandom_range(0, 99) < 7);
      if ($urandom_range(0, 19) == 0) begin
        ie_data = 1'($urandom); ie_err = 1'($urandom);
        ie_idle = 1'($urandom); ie_thr = 1'($urandom);
        dma_en  = 1'($urandom);
        thr_level = CNT_W'($urandom_range(0, DEPTH));
      end
      tick();
    end
    quiet();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset(0);
    chk(!data_ready && rx_level == 0 && !ovr_flag && !frm_flag && !idle_flag
        && !dma_req && !irq && !thr_reached, "R1 reset", {data_ready, ovr_flag, irq}, 0);

    // Single mode
    put(8'h5A);
    chk(data_ready && rd_data == 8'h5A, "R2 store", rd_data, 8'h5A);
    put(8'hC3);
    chk(ovr_flag && rd_data == 8'h5A && rx_level == 1, "R4 keep old", rd_data, 8'h5A);
    rd_pop = 1; tick(); quiet();
    chk(!data_ready, "R3 pop clears", data_ready, 0);
    rd_pop = 1; tick(); quiet();
    chk(rx_level == 0, "R3 empty pop", rx_level, 0);
    clr_ovr = 1; tick(); quiet();
    chk(!ovr_flag, "R7 clear", ovr_flag, 0);
    put(8'h11);
    rd_pop = 1; char_done = 1; char_data = 8'h22; tick(); quiet();
    chk(ovr_flag && !data_ready, "R6 read+overrun", {ovr_flag, data_ready}, 2'b10);
    put(8'h33);
    put(8'h44); // overrun with clear in same cycle follows
    clr_ovr = 1; char_done = 1; char_data = 8'h55; tick(); quiet();
    chk(ovr_flag, "R7 set wins", ovr_flag, 1);
    char_done = 1; char_break = 1; tick(); quiet();
    chk(frm_flag && rx_level == 1, "R8 break", frm_flag, 1);
    idle_seen = 1; tick(); quiet();
    chk(idle_flag && !irq, "R9 idle no enable", irq, 0);
    ie_idle = 1; tick();
    chk(irq, "R9 idle enabled", irq, 1);
    ie_idle = 0; dma_en = 1; tick();
    chk(dma_req, "R11 dma_req", dma_req, 1);
    dma_ack = 1; tick(); quiet();
    chk(!dma_req && rx_level == 0, "R11 dma_ack pops", dma_req, 0);
    ie_err = 1; tick();
    chk(irq, "R12 error irq", irq, 1);
    random_run(3000);

    // Queue mode
    ie_data = 0; ie_err = 0; ie_idle = 0; ie_thr = 1; dma_en = 0;
    thr_level = CNT_W'(4);
    do_reset(1);
    for (int i = 1; i <= DEPTH; i++) begin
      put(DW'(i));
      if (i == 3) chk(!thr_reached, "R10 below", thr_reached, 0);
      if (i == 4) chk(thr_reached && irq, "R10 at thr", thr_reached, 1);
    end
    chk(rx_level == DEPTH && !ovr_flag, "R5 full", rx_level, DEPTH);
    put(8'hEE);
    chk(ovr_flag && rx_level == DEPTH && rd_data == 8'h01, "R5 overrun", rd_data, 1);
    rd_pop = 1; char_done = 1; char_data = 8'hDD; tick(); quiet();
    chk(rx_level == DEPTH - 1 && rd_data == 8'h02, "R6 fifo read+overrun", rd_data, 2);
    for (int i = 2; i <= 5; i++) begin
      chk(rd_data == DW'(i), "R3 order", rd_data, i);
      rd_pop = 1; tick(); quiet();
    end
    chk(!thr_reached, "R10 drops below", thr_reached, 0);
    random_run(3000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule